// File: doc/BRIEF.md
# Variable-Latency Five-Stage Integer Pipeline

This block is an in-order integer pipeline with five stages: fetch, decode, operand fetch, execute and write-back. It runs a short program held in a small instruction store over an 8-entry register file. The supported operations are register-to-register add, subtract, multiply and divide. Every stage except execute takes one cycle. Execute takes one cycle for add and subtract, three for multiply and six for divide. While execute is occupied for more than one cycle, the three stages in front of it freeze. Results are bypassed straight into the operands of the next instruction entering execute, so a dependent instruction never waits for write-back.

Software first fills the instruction store and the register file through one load stream. That stream is a valid/ready interface: `load_ready` is high only while the core is idle. A word is taken on every cycle where `load_valid` and `load_ready` are both high, and a word offered while the core runs is held off. A `start` pulse with a program length then runs the program. Each write-back is reported on a retire stream that is valid-only and takes no back-pressure. When the last instruction has retired, `done` goes high and `cycle_count` holds the run length. Final register values can be read through a combinational peek port.

Top module: `vlp_pipeline`

## Requirements
- R1: `load_ready` is 1 exactly while the core is idle. On a cycle where `load_valid` and `load_ready` are both 1, the word is written: `load_sel`=0 writes the instruction store at `load_addr`, and `load_sel`=1 writes register `load_addr`. A load offered while the core is running has no effect on any register.
- R2: Instructions use the low 11 bits of a word: opcode in [10:9], destination in [8:6], first source in [5:3], second source in [2:0]. The opcodes are 00 add, 01 subtract, 10 multiply and 11 unsigned divide. The result is the low 16 bits of the operation, and subtraction wraps.
- R3: A divide by zero yields all ones (0xFFFF) and takes the same six execute cycles as any other divide.
- R4: Execute takes 1 cycle for add and subtract, 3 for multiply and 6 for divide. The other four stages take one cycle each. Instruction k (counted from 0) enters execute in cycle max(k+4, end of execute of instruction k-1 plus 1), and retires in the cycle after its execute ends.
- R5: While execute still has cycles left, fetch, decode and operand fetch hold their contents, and the retire stream shows a bubble in the next cycle.
- R6: A dependent instruction receives the producer's result through bypassing from execute or write-back. Chains of true dependences give the same register values as sequential execution, with no extra stall cycles.
- R7: `retire_valid` is high for exactly one cycle per instruction, in program order, with the destination on `retire_rd` and the written value on `retire_value`. At most one instruction retires per cycle, and only while the core is busy.
- R8: `cycle_count` is 1 in the first fetch cycle after `start` and increases by 1 each cycle. In the write-back cycle of the last instruction it equals the run length, after which `busy` falls, `done` rises and the count holds. The program add r2=r1+r2, divide r4=r3/r2, multiply r6=r5*r4 runs in 14 cycles.
- R9: A `start` with `prog_len`=0 sets `done` in the next cycle with `cycle_count`=0 and leaves the core idle.
- R10: `start` is ignored while the core is busy.
- R11: After reset the core is idle, `done`=0, `cycle_count`=0, `load_ready`=1, `retire_valid`=0, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Load word offered |
| load_ready | output | 1 | Load word accepted (core idle) |
| load_sel | input | 1 | 0: instruction store, 1: register file |
| load_addr | input | 4 | Target index of the load |
| load_data | input | 16 | Instruction word or register value |
| start | input | 1 | Begin running the program |
| prog_len | input | 5 | Number of instructions to run |
| busy | output | 1 | Program running |
| done | output | 1 | Last run complete |
| cycle_count | output | 16 | Cycles since the first fetch |
| retire_valid | output | 1 | An instruction is in write-back |
| retire_rd | output | 3 | Destination register being written |
| retire_value | output | 16 | Value being written |
| peek_addr | input | 3 | Register to observe |
| peek_data | output | 16 | Value of the observed register |

## Verification
The checker assumes that `start` and load words arrive only through their documented handshakes. It also assumes that `prog_len` never exceeds the instruction store depth, and that the store entries below `prog_len` were loaded before the run. The bench keeps to these conditions: it loads every program word before asserting `start`, and it uses lengths of 0, 3, 6 and 8 against a 16-entry store. Mid-run `start` pulses and load attempts are driven on purpose. They are valid port activity that the core must ignore, so the checker makes no assumption that excludes them.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } op_e;
endpackage

// File: rtl/vlp_imem.sv
module vlp_imem #(
  parameter int AW = 4,
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vlp_regfile.sv
module vlp_regfile #(
  parameter int RAW = 3,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] ra_a,
  output logic [DW-1:0]  rd_a,
  input  logic [RAW-1:0] ra_b,
  output logic [DW-1:0]  rd_b,
  input  logic [RAW-1:0] ra_p,
  output logic [DW-1:0]  rd_p
);
  localparam int NREG = 1 << RAW;
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_p = regs[ra_p];
endmodule

// File: rtl/vlp_exec.sv
module vlp_exec
  import vlp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int RAW     = 3,
  parameter int LAT_ADD = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 6,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  op_e              in_op,
  input  logic [RAW-1:0]   in_rd,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  output logic             accept,
  output logic             occupied,
  output logic [LAT_W-1:0] remain,
  output logic             out_valid,
  output logic [RAW-1:0]   out_rd,
  output logic [DW-1:0]    out_value
);
  op_e              op_q;
  logic [RAW-1:0]   rd_q;
  logic [DW-1:0]    a_q, b_q;
  logic [LAT_W-1:0] cnt_q;
  logic             v_q;
  logic [LAT_W-1:0] load_cnt;

  assign accept    = !v_q || (cnt_q == '0);
  assign occupied  = v_q;
  assign remain    = cnt_q;
  assign out_valid = v_q && (cnt_q == '0);
  assign out_rd    = rd_q;

  always_comb begin
    unique case (in_op)
      OP_MUL:  load_cnt = LAT_W'(LAT_MUL - 1);
      OP_DIV:  load_cnt = LAT_W'(LAT_DIV - 1);
      default: load_cnt = LAT_W'(LAT_ADD - 1);
    endcase
  end

  always_comb begin
    unique case (op_q)
      OP_ADD:  out_value = a_q + b_q;
      OP_SUB:  out_value = a_q - b_q;
      OP_MUL:  out_value = a_q * b_q;
      default: out_value = (b_q == '0) ? '1 : a_q / b_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      op_q  <= OP_ADD;
      rd_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      v_q <= in_valid;
      if (in_valid) begin
        op_q  <= in_op;
        rd_q  <= in_rd;
        a_q   <= in_a;
        b_q   <= in_b;
        cnt_q <= load_cnt;
      end
    end else begin
      cnt_q <= cnt_q - LAT_W'(1);
    end
  end
endmodule

// File: rtl/vlp_pipeline.sv
module vlp_pipeline
  import vlp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_AW  = 3,
  parameter int IMEM_AW = 4,
  parameter int CNT_W   = 16,
  parameter int LAT_ADD = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 6,
  localparam int INSTR_W = 2 + 3 * REG_AW,
  localparam int LOAD_AW = (IMEM_AW > REG_AW) ? IMEM_AW : REG_AW,
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL,
  localparam int LAT_W   = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_valid,
  output logic               load_ready,
  input  logic               load_sel,
  input  logic [LOAD_AW-1:0] load_addr,
  input  logic [DATA_W-1:0]  load_data,
  input  logic               start,
  input  logic [IMEM_AW:0]   prog_len,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   cycle_count,
  output logic               retire_valid,
  output logic [REG_AW-1:0]  retire_rd,
  output logic [DATA_W-1:0]  retire_value,
  input  logic [REG_AW-1:0]  peek_addr,
  output logic [DATA_W-1:0]  peek_data
);
  typedef struct packed {
    logic              v;
    op_e               op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
  } slot_t;

  logic               running, done_q;
  logic [CNT_W-1:0]   cyc_q;
  logic [IMEM_AW:0]   pc, len_q;
  logic               d_v;
  logic [INSTR_W-1:0] d_instr, f_instr;
  slot_t              o_q, d_dec;
  logic               w_v;
  logic [REG_AW-1:0]  w_rd;
  logic [DATA_W-1:0]  w_val;

  logic               fetch_v, adv, finishing, load_fire;
  logic               ex_occ, ex_out_v;
  logic [LAT_W-1:0]   ex_cnt;
  logic [REG_AW-1:0]  ex_out_rd;
  logic [DATA_W-1:0]  ex_out_val;
  logic [DATA_W-1:0]  rf_a, rf_b, opnd_a, opnd_b;
  logic               rf_we;
  logic [REG_AW-1:0]  rf_waddr;
  logic [DATA_W-1:0]  rf_wdata;

  assign load_ready   = !running;
  assign load_fire    = load_valid && !running;
  assign busy         = running;
  assign done         = done_q;
  assign cycle_count  = cyc_q;
  assign retire_valid = w_v;
  assign retire_rd    = w_rd;
  assign retire_value = w_val;

  assign fetch_v   = running && (pc < len_q);
  assign finishing = w_v && !d_v && !o_q.v && !ex_occ && (pc == len_q);

  vlp_imem #(.AW(IMEM_AW), .IW(INSTR_W)) u_imem (
    .clk   (clk),
    .we    (load_fire && !load_sel),
    .waddr (load_addr[IMEM_AW-1:0]),
    .wdata (load_data[INSTR_W-1:0]),
    .raddr (pc[IMEM_AW-1:0]),
    .rdata (f_instr)
  );

  // Decode stage: split the raw word into fields.
  always_comb begin
    d_dec.v   = d_v;
    d_dec.op  = op_e'(d_instr[INSTR_W-1 -: 2]);
    d_dec.rd  = d_instr[3*REG_AW-1 -: REG_AW];
    d_dec.rs1 = d_instr[2*REG_AW-1 -: REG_AW];
    d_dec.rs2 = d_instr[REG_AW-1:0];
  end

  assign rf_we    = w_v || (load_fire && load_sel);
  assign rf_waddr = w_v ? w_rd  : load_addr[REG_AW-1:0];
  assign rf_wdata = w_v ? w_val : load_data;

  vlp_regfile #(.RAW(REG_AW), .DW(DATA_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra_a  (o_q.rs1),
    .rd_a  (rf_a),
    .ra_b  (o_q.rs2),
    .rd_b  (rf_b),
    .ra_p  (peek_addr),
    .rd_p  (peek_data)
  );

  // Operand fetch: youngest producer wins (execute, then write-back, then file).
  always_comb begin
    if (ex_out_v && ex_out_rd == o_q.rs1)  opnd_a = ex_out_val;
    else if (w_v && w_rd == o_q.rs1)       opnd_a = w_val;
    else                                   opnd_a = rf_a;
    if (ex_out_v && ex_out_rd == o_q.rs2)  opnd_b = ex_out_val;
    else if (w_v && w_rd == o_q.rs2)       opnd_b = w_val;
    else                                   opnd_b = rf_b;
  end

  vlp_exec #(
    .DW(DATA_W), .RAW(REG_AW), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL),
    .LAT_DIV(LAT_DIV), .LAT_W(LAT_W)
  ) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (o_q.v && running),
    .in_op     (o_q.op),
    .in_rd     (o_q.rd),
    .in_a      (opnd_a),
    .in_b      (opnd_b),
    .accept    (adv),
    .occupied  (ex_occ),
    .remain    (ex_cnt),
    .out_valid (ex_out_v),
    .out_rd    (ex_out_rd),
    .out_value (ex_out_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      done_q  <= 1'b0;
      cyc_q   <= '0;
      pc      <= '0;
      len_q   <= '0;
      d_v     <= 1'b0;
      d_instr <= '0;
      o_q     <= '0;
      w_v     <= 1'b0;
      w_rd    <= '0;
      w_val   <= '0;
    end else if (!running) begin
      if (start) begin
        running <= (prog_len != '0);
        done_q  <= (prog_len == '0);
        cyc_q   <= (prog_len != '0) ? CNT_W'(1) : '0;
        pc      <= '0;
        len_q   <= prog_len;
        d_v     <= 1'b0;
        o_q     <= '0;
        w_v     <= 1'b0;
      end
    end else begin
      if (finishing) begin
        running <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        cyc_q <= cyc_q + CNT_W'(1);
      end
      if (adv) begin
        d_v     <= fetch_v;
        d_instr <= f_instr;
        o_q     <= d_dec;
        pc      <= pc + {{IMEM_AW{1'b0}}, fetch_v};
      end
      w_v   <= ex_out_v;
      w_rd  <= ex_out_rd;
      w_val <= ex_out_val;
    end
  end
endmodule

// File: rtl/vlp_pipeline_chk.sv
module vlp_pipeline_chk #(
  parameter int CNT_W   = 16,
  parameter int IMEM_AW = 4,
  parameter int LAT_W   = 3,
  parameter int LAT_DIV = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IMEM_AW:0] prog_len,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cycle_count,
  input logic             retire_valid,
  input logic [IMEM_AW:0] pc,
  input logic             ex_occ,
  input logic [LAT_W-1:0] ex_cnt
);
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cycle_count == $past(cycle_count) + CNT_W'(1));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(cycle_count));

  p_stall_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ex_occ && ex_cnt != '0 |=> $stable(pc));

  p_wb_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ex_occ && ex_cnt != '0 |=> !retire_valid);

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ex_occ |-> int'(ex_cnt) < LAT_DIV);

  p_retire_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> busy);

  p_empty_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && prog_len == '0 |=> done && !busy && cycle_count == '0);
endmodule

bind vlp_pipeline vlp_pipeline_chk #(
  .CNT_W(CNT_W), .IMEM_AW(IMEM_AW), .LAT_W(LAT_W), .LAT_DIV(LAT_DIV)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .prog_len    (prog_len),
  .busy        (busy),
  .done        (done),
  .cycle_count (cycle_count),
  .retire_valid(retire_valid),
  .pc          (pc),
  .ex_occ      (ex_occ),
  .ex_cnt      (ex_cnt)
);

// File: tb/vlp_pipeline_tb.sv
`timescale 1ns/1ps
module vlp_pipeline_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic        load_sel = 1'b0;
  logic [3:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic        start = 1'b0;
  logic [4:0]  prog_len = '0;
  logic        busy, done, retire_valid;
  logic [15:0] cycle_count, retire_value, peek_data;
  logic [2:0]  retire_rd;
  logic [2:0]  peek_addr = '0;

  always #4 clk = ~clk;

  vlp_pipeline u_dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_sel(load_sel), .load_addr(load_addr), .load_data(load_data),
    .start(start), .prog_len(prog_len), .busy(busy), .done(done),
    .cycle_count(cycle_count), .retire_valid(retire_valid), .retire_rd(retire_rd),
    .retire_value(retire_value), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int pop [16];
  int prd [16];
  int prs1[16];
  int prs2[16];
  int mreg[8];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lat(input int op);
    return (op == 2) ? 3 : (op == 3) ? 6 : 1;
  endfunction

  function automatic int alu(input int op, input int a, input int b);
    case (op)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: return (a * b) & 16'hFFFF;
      default: return (b == 0) ? 16'hFFFF : a / b;
    endcase
  endfunction

  task automatic load_word(input bit sel, input int addr, input int data);
    @(negedge clk);
    chk("R1", "load_ready while idle", load_ready, 1);
    load_valid = 1'b1; load_sel = sel; load_addr = 4'(addr); load_data = 16'(data);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic set_reg(input int r, input int v);
    mreg[r] = v;
    load_word(1'b1, r, v);
  endtask

  task automatic put_ins(input int k, input int op, input int rd, input int rs1, input int rs2);
    pop[k] = op; prd[k] = rd; prs1[k] = rs1; prs2[k] = rs2;
    load_word(1'b0, k, (op << 9) | (rd << 6) | (rs1 << 3) | rs2);
  endtask

  task automatic run_prog(input int n, input string vtag, input int exp_total);
    int exend[16];
    int wbc[16];
    int vals[16];
    bit zdiv[16];
    int total;
    total = 0;
    for (int k = 0; k < n; k++) begin
      int a, b, exin;
      a = mreg[prs1[k]]; b = mreg[prs2[k]];
      vals[k] = alu(pop[k], a, b);
      zdiv[k] = (pop[k] == 3) && (b == 0);
      mreg[prd[k]] = vals[k];
      exin = k + 4;
      if (k > 0 && exend[k-1] + 1 > exin) exin = exend[k-1] + 1;
      exend[k] = exin + lat(pop[k]) - 1;
      wbc[k] = exend[k] + 1;
      total = wbc[k];
    end
    if (exp_total >= 0) chk("R8", "model run length", total, exp_total);
    @(negedge clk);
    prog_len = 5'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk("R9", "done after empty run", done, 1);
      chk("R9", "count after empty run", cycle_count, 0);
      chk("R9", "busy after empty run", busy, 0);
      return;
    end
    for (int c = 1; c <= total; c++) begin
      int ek;
      if (c > 1) @(negedge clk);
      ek = -1;
      for (int k = 0; k < n; k++) if (wbc[k] == c) ek = k;
      chk("R8", "cycle_count", cycle_count, c);
      chk("R8", "busy during run", busy, 1);
      chk("R8", "done during run", done, 0);
      chk(ek >= 0 ? "R4" : "R5", "retire_valid", retire_valid, ek >= 0);
      if (ek >= 0) begin
        chk("R7", "retire_rd", retire_rd, prd[ek]);
        chk(zdiv[ek] ? "R3" : vtag, "retire_value", retire_value, vals[ek]);
      end
      if (c == 2) begin
        chk("R1", "load_ready while busy", load_ready, 0);
        start = 1'b1;
        load_valid = 1'b1; load_sel = 1'b1; load_addr = 4'd7; load_data = 16'h1234;
      end
      if (c == 3) begin
        chk("R10", "count unaffected by start", cycle_count, 3);
        start = 1'b0; load_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8", "done at end", done, 1);
    chk("R8", "busy at end", busy, 0);
    chk("R8", "final count", cycle_count, total);
    for (int r = 0; r < 8; r++) begin
      peek_addr = 3'(r);
      #1;
      chk(r == 7 ? "R1" : vtag, "register after run", peek_data, mreg[r]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) mreg[r] = 0;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11", "busy in reset", busy, 0);
    chk("R11", "done in reset", done, 0);
    chk("R11", "count in reset", cycle_count, 0);
    chk("R11", "load_ready in reset", load_ready, 1);
    chk("R11", "retire_valid in reset", retire_valid, 0);
    rst_n = 1'b1;
    for (int r = 0; r < 8; r++) begin
      peek_addr = 3'(r);
      #1;
      chk("R11", "register after reset", peek_data, 0);
    end

    // Program 1: dependent chain add -> divide -> multiply
    set_reg(1, 7); set_reg(2, 5); set_reg(3, 100); set_reg(5, 3);
    peek_addr = 3'd3;
    #1;
    chk("R1", "register load", peek_data, 100);
    put_ins(0, 0, 2, 1, 2);
    put_ins(1, 3, 4, 3, 2);
    put_ins(2, 2, 6, 5, 4);
    run_prog(3, "R6", 14);

    // Program 2: mixed operations, wrap and divide by zero
    put_ins(0, 1, 4, 1, 3);
    put_ins(1, 2, 1, 3, 3);
    put_ins(2, 3, 5, 3, 0);
    put_ins(3, 0, 0, 5, 2);
    put_ins(4, 3, 6, 1, 2);
    put_ins(5, 0, 2, 2, 2);
    run_prog(6, "R2", -1);

    // Program 3: empty program
    run_prog(0, "R9", 0);

    // Program 4: back-to-back dependences across all opcodes
    set_reg(0, 9); set_reg(3, 4);
    for (int k = 0; k < 8; k++) put_ins(k, k % 4, (k + 1) % 7, k % 7, (k + 2) % 7);
    run_prog(8, "R6", -1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule